// File: doc/BRIEF.md
# Bit Scan and Zero Count Unit

This unit locates set bits in a 32-bit or 64-bit operand. It has four operations. A forward scan gives the position of the lowest set bit. A reverse scan gives the position of the highest set bit. The other two count the leading zeros or the trailing zeros of the operand. The caller supplies the operand, an operation code, a width select and the value its destination register holds now. One cycle later the unit returns a registered result, a zero flag and a write-enable for that destination.

An all-zero operand has a defined outcome in every operation. The two scans leave the destination as it was: the result repeats the supplied destination value and no write is requested. The two counts return the operand width. Because a scan of zero keeps the old value, software can build a 64-bit reverse scan from two 32-bit scans with fixed offsets. That sequence gives -1 when all 64 bits are zero.

Top module: `bitscan_unit`

## Requirements
- R1: With op code 2'b00 (forward scan) and a non-zero operand, the result is the index of the least significant set bit and the write-enable is 1.
- R2: With op code 2'b01 (reverse scan) and a non-zero operand, the result is the index of the most significant set bit and the write-enable is 1.
- R3: With op code 2'b10 the result is the count of leading zeros, and with op code 2'b11 it is the count of trailing zeros. Both are counted within the selected width.
- R4: For a scan (op code 2'b00 or 2'b01) of a zero operand, the result equals the supplied destination value in all 64 bits and the write-enable is 0.
- R5: For a count (op code 2'b10 or 2'b11) of a zero operand, the result is the operand width (32 or 64) and the write-enable is 1.
- R6: In every operation, the zero flag is 1 when the operand bits under consideration are all zero and 0 otherwise.
- R7: When `wide` is 0 the width is 32 and operand bits 63:32 have no effect on any output. When `wide` is 1 the width is 64.
- R8: `out_valid` is 1 exactly one cycle after `in_valid`. The write-enable is never 1 while `out_valid` is 0. After reset `out_valid`, `wr_en`, `zero_flag` and `result` are all 0.
- R9: Two chained 32-bit reverse scans give a correct 64-bit reverse scan with -1 for an all-zero value. The chain starts from a destination of -1, scans the low half, subtracts 32, scans the high half and adds 32.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request strobe |
| operand | input | 64 | Value to scan |
| op | input | 2 | 00 forward scan, 01 reverse scan, 10 leading-zero count, 11 trailing-zero count |
| wide | input | 1 | 1 selects 64-bit width, 0 selects 32-bit width |
| dest_in | input | 64 | Current destination value |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| result | output | 64 | Index, count or preserved destination |
| zero_flag | output | 1 | Operand was zero within the width |
| wr_en | output | 1 | Destination should be written |

## Verification
The bench drives zero operands in all four operations, with destination values that a zero result could not produce by accident. A unit that cleared or rewrote the destination on a zero scan would fail there, and so would one that returned 0 or 31 instead of the width on a zero count. It sets bits only above bit 31 while `wide` is 0. This catches a unit that lets the upper half leak into the result or the flag. Single-bit operands at positions 0, 31, 32 and 63 expose off-by-one errors in the index and the counts. The chained two-step 64-bit reverse scan gives a wrong value for an all-zero input if the zero case writes anything.

// File: rtl/bitscan_unit.sv
module bitscan_unit #(
  parameter int unsigned XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [XLEN-1:0] operand,
  input  logic [1:0]      op,
  input  logic            wide,
  input  logic [XLEN-1:0] dest_in,
  output logic            out_valid,
  output logic [XLEN-1:0] result,
  output logic            zero_flag,
  output logic            wr_en
);
  localparam int unsigned HALF = XLEN / 2;
  localparam int unsigned IW   = $clog2(XLEN) + 1;

  logic [XLEN-1:0] masked;
  logic [IW-1:0]   lo_idx, hi_idx, width_val;
  logic            none_set, is_scan;
  logic [XLEN-1:0] next_res;

  assign masked    = wide ? operand : {{(XLEN-HALF){1'b0}}, operand[HALF-1:0]};
  assign none_set  = ~|masked;
  assign width_val = wide ? IW'(XLEN) : IW'(HALF);
  assign is_scan   = ~op[1];

  always_comb begin
    lo_idx = '0;
    hi_idx = '0;
    for (int i = XLEN - 1; i >= 0; i--)
      if (masked[i]) lo_idx = IW'(i);
    for (int i = 0; i < XLEN; i++)
      if (masked[i]) hi_idx = IW'(i);
  end

  always_comb begin
    unique case (op)
      2'b00: next_res = none_set ? dest_in : XLEN'(lo_idx);
      2'b01: next_res = none_set ? dest_in : XLEN'(hi_idx);
      2'b10: next_res = none_set ? XLEN'(width_val) : XLEN'(width_val - IW'(1) - hi_idx);
      default: next_res = none_set ? XLEN'(width_val) : XLEN'(lo_idx);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      wr_en     <= 1'b0;
      zero_flag <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      wr_en     <= in_valid & ~(is_scan & none_set);
      if (in_valid) begin
        result    <= next_res;
        zero_flag <= none_set;
      end
    end
  end

  AST_VALID_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(in_valid)); // R8
  AST_WE_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> out_valid); // R8
  AST_SCAN_ZERO_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !op[1] && operand == '0) |=> (result == $past(dest_in) && !wr_en && zero_flag)); // R4
  AST_COUNT_ZERO_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op[1] && operand == '0) |=> (result == (($past(wide)) ? XLEN : HALF) && wr_en)); // R5
  AST_WIDE_HIGH_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && wide && operand[XLEN-1:HALF] != '0) |=> !zero_flag); // R6
  AST_NARROW_IGNORES_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !wide && operand[HALF-1:0] == '0 && op == 2'b01) |=> zero_flag); // R7
  AST_INDEX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !zero_flag) |-> result < XLEN); // R1
endmodule

// File: tb/tb_bitscan_unit.sv
module tb_bitscan_unit;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [63:0] operand = '0;
  logic [1:0]  op = 2'b00;
  logic        wide = 1'b1;
  logic [63:0] dest_in = '0;
  logic        out_valid, zero_flag, wr_en;
  logic [63:0] result;
  int total = 0, bad = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  bitscan_unit dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .operand(operand), .op(op),
    .wide(wide), .dest_in(dest_in), .out_valid(out_valid), .result(result),
    .zero_flag(zero_flag), .wr_en(wr_en)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int lowest(input logic [63:0] v, input int w);
    int k = 0;
    while (k < w && !v[k]) k++;
    return k;
  endfunction

  function automatic int highest(input logic [63:0] v, input int w);
    int k = w - 1;
    while (k >= 0 && !v[k]) k--;
    return k;
  endfunction

  task automatic run(input logic [63:0] v, input logic [1:0] m, input logic w,
                     input logic [63:0] d, output logic [63:0] r);
    @(negedge clk);
    operand = v; op = m; wide = w; dest_in = d; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    r = result;
    chk("R8 out_valid after request", 64'(out_valid), 64'd1);
  endtask

  task automatic one(input string tag, input logic [63:0] v, input logic [1:0] m, input logic w,
                     input logic [63:0] d);
    logic [63:0] r, e;
    int wd = w ? 64 : 32;
    logic [63:0] mv = w ? v : {32'd0, v[31:0]};
    logic z = (mv == 64'd0);
    logic we = !(z && !m[1]);
    run(v, m, w, d, r);
    case (m)
      2'b00: e = z ? d : 64'(lowest(mv, wd));
      2'b01: e = z ? d : 64'(highest(mv, wd));
      2'b10: e = 64'(wd - 1 - highest(mv, wd));
      default: e = 64'(lowest(mv, wd));
    endcase
    chk({tag, " result"}, r, e);
    chk({tag, " R6 zero_flag"}, 64'(zero_flag), 64'(z));
    chk({tag, " wr_en"}, 64'(wr_en), 64'(we));
  endtask

  task automatic t_reset;
    chk("R8 reset out_valid", 64'(out_valid), 64'd0);
    chk("R8 reset wr_en", 64'(wr_en), 64'd0);
    chk("R8 reset zero_flag", 64'(zero_flag), 64'd0);
    chk("R8 reset result", result, 64'd0);
  endtask

  task automatic t_forward;
    one("R1 fwd bit0", 64'h1, 2'b00, 1'b1, 64'hAA);
    one("R1 fwd bit63", 64'h8000_0000_0000_0000, 2'b00, 1'b1, 64'hAA);
    one("R1 fwd mixed", 64'hF000_0100_0000_0000, 2'b00, 1'b1, 64'h0);
    one("R1 fwd 32b", 64'h0000_0000_8000_0010, 2'b00, 1'b0, 64'h0);
  endtask

  task automatic t_reverse;
    one("R2 rev bit32", 64'h1_0000_0000, 2'b01, 1'b1, 64'h5);
    one("R2 rev bit31", 64'h8000_0001, 2'b01, 1'b0, 64'h5);
    one("R2 rev all", 64'hFFFF_FFFF_FFFF_FFFF, 2'b01, 1'b1, 64'h5);
  endtask

  task automatic t_counts;
    one("R3 clz 64", 64'h0000_0000_0001_0000, 2'b10, 1'b1, 64'h0);
    one("R3 clz 32", 64'h0000_0000_0001_0000, 2'b10, 1'b0, 64'h0);
    one("R3 ctz 64", 64'h8000_0000_0000_0000, 2'b11, 1'b1, 64'h0);
    one("R3 clz top", 64'h8000_0000_0000_0000, 2'b10, 1'b1, 64'h0);
  endtask

  task automatic t_zero;
    one("R4 fwd zero keep", 64'h0, 2'b00, 1'b1, 64'hDEAD_BEEF_1234_5678);
    one("R4 rev zero keep", 64'h0, 2'b01, 1'b0, 64'hFFFF_FFFF_FFFF_FFC0);
    one("R5 clz zero 64", 64'h0, 2'b10, 1'b1, 64'h77);
    one("R5 ctz zero 32", 64'h0, 2'b11, 1'b0, 64'h77);
  endtask

  task automatic t_narrow;
    one("R7 high only fwd", 64'hFFFF_FFFF_0000_0000, 2'b00, 1'b0, 64'h1234);
    one("R7 high only clz", 64'h8000_0000_0000_0000, 2'b10, 1'b0, 64'h1234);
    one("R7 high ignored ctz", 64'hFFFF_0000_0000_0100, 2'b11, 1'b0, 64'h0);
  endtask

  task automatic t_idle;
    @(negedge clk);
    chk("R8 out_valid idle", 64'(out_valid), 64'd0);
    chk("R8 wr_en idle", 64'(wr_en), 64'd0);
  endtask

  task automatic chain(input logic [63:0] v);
    logic [63:0] d;
    logic [63:0] e;
    d = '1;
    run({32'd0, v[31:0]}, 2'b01, 1'b0, d, d);
    d = d - 64'd32;
    run({32'd0, v[63:32]}, 2'b01, 1'b0, d, d);
    d = d + 64'd32;
    e = (v == 64'd0) ? '1 : 64'(highest(v, 64));
    chk("R9 chained 64-bit reverse scan", d, e);
  endtask

  task automatic t_chain;
    chain(64'h0);
    chain(64'h0000_0000_0040_0000);
    chain(64'h0000_0200_0000_0001);
    chain(64'h8000_0000_0000_0000);
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(CLK_P * 2 + 1);
    t_reset;
    @(negedge clk);
    rst_n = 1'b1;
    t_forward;
    t_reverse;
    t_counts;
    t_zero;
    t_narrow;
    t_idle;
    t_chain;
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule